// File: doc/BRIEF.md
# Strap-Latched Clock Mode Selector

This block models the output side of a system clock generator. At power-up it reads a 3-bit strap value once and decodes it into a divide ratio and an inversion setting for each output group: host CPU, SDRAM, fixed 66 MHz, PCI, APIC and 48 MHz. Every group is a divided copy of one source clock, and one synchronized start lets all groups begin on the same source edge. The reference output passes the crystal clock through.

In the normal modes the source is a fast synthesized clock, nominally 2400 MHz, so that every output frequency is a whole-number division of it. In test mode every group is divided from the crystal-input clock instead, which then carries an external test clock, at fixed small ratios. A tri-state mode releases every output for board-level testing. Each group has an output-enable bit. The pads use these bits to drive or float the group's pins.

Top module: `clkmode_sel_top`

## Requirements
- R1: The strap value is captured at the first rising `clk_xtal` edge after `rst_n` is released. Any later change of `strap_i` has no effect until the next reset.
- R2: With the strap at 3'b010, 3'b011, 3'b110 and 3'b111, the CPU group divides `clk_syn` by 36, 24, 18 and 18 in that order. The SDRAM group divides it by 24, 24, 18 and 24.
- R3: In every normal mode the 66 MHz group divides `clk_syn` by 36, the PCI group by 72 and the 48 MHz group by 50.
- R4: Strap 3'b010 complements the CPU and 66 MHz groups. Straps 3'b011 and 3'b111 complement the CPU and SDRAM groups. Strap 3'b110 and test mode complement no group.
- R5: Straps 3'b001 and 3'b101 select test mode. Every group is then divided from `clk_xtal`: CPU, SDRAM and 48 MHz by 2, the 66 MHz group by 3, and PCI and APIC by 6.
- R6: Straps 3'b000 and 3'b100 select tri-state mode. All seven bits of `grp_oe_o` then stay 0 and every clock output stays low.
- R7: A group with ratio N, sampled after the k-th source edge that follows the edge where its enable rose (k = 0 at that edge), is high exactly when (k mod N) < N/2 with integer division. A complemented group shows the inverse.
- R8: The enables of the six divided groups rise on the same source edge. All groups count their phase from that common edge.
- R9: The APIC outputs equal the PCI outputs at every instant.
- R10: `grp_oe_o[6]` (REF) stays 0 and `ref_clk_o` stays low until one `clk_xtal` edge after the straps are captured. Outside tri-state mode, `ref_clk_o` then follows `clk_xtal`.
- R11: While reset is asserted and until a group's enable rises, that group's clock outputs are low. The enable bits are ordered CPU 0, SDRAM 1, 66 MHz 2, PCI 3, APIC 4, 48 MHz 5, REF 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_syn | input | 1 | Fast synthesized source clock for the normal modes |
| clk_xtal | input | 1 | Crystal clock, or the external test clock in test mode |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| strap_i | input | 3 | Frequency-select straps, sampled once after reset |
| cpu_clk_o | output | N_CPU | Host CPU clock copies |
| sdram_clk_o | output | N_SDRAM | SDRAM clock copies |
| v66_clk_o | output | N_V66 | Fixed 66 MHz clock copies |
| pci_clk_o | output | N_PCI | PCI clock copies |
| apic_clk_o | output | N_APIC | APIC clock copies, same phase as PCI |
| usb_clk_o | output | N_USB | 48 MHz clock copies |
| ref_clk_o | output | 1 | Reference clock (crystal pass-through) |
| grp_oe_o | output | 7 | Output enable per group, ordered as in R11 |

## Verification
The straps take effect on the first crystal edge after reset release. The REF enable follows one crystal edge later. The divided groups start two or three source edges after the capture, because the start crosses into the source domain. The bench therefore anchors each run on the source edge where the group enables rise, rather than predicting that crossing. From that anchor the scoreboard queues one expected vector for every later source edge, and the monitor compares each vector a quarter of a source period after its edge. REF, tri-state and reset checks are sampled one time unit after a crystal edge, before the next one.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  typedef enum logic [2:0] {
    MODE_TRI  = 3'd0,
    MODE_TEST = 3'd1,
    MODE_M0   = 3'd2,
    MODE_M1   = 3'd3,
    MODE_M2   = 3'd4,
    MODE_M3   = 3'd5
  } clk_mode_e;

  // divided group indices; REF sits above them in the enable vector
  localparam int GRP_CPU   = 0;
  localparam int GRP_SDRAM = 1;
  localparam int GRP_V66   = 2;
  localparam int GRP_PCI   = 3;
  localparam int GRP_APIC  = 4;
  localparam int GRP_USB   = 5;
  localparam int N_DIV_GRP = 6;
  localparam int GRP_REF   = 6;
  localparam int N_OE      = 7;
  localparam int STRAP_W   = 3;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic clk_mode_e decode_strap(input logic [STRAP_W-1:0] s);
    clk_mode_e m;
    case (s)
      3'b000, 3'b100: m = MODE_TRI;
      3'b001, 3'b101: m = MODE_TEST;
      3'b010:         m = MODE_M0;
      3'b011:         m = MODE_M1;
      3'b110:         m = MODE_M2;
      default:        m = MODE_M3;
    endcase
    return m;
  endfunction

  function automatic logic [N_DIV_GRP-1:0] inv_mask(input clk_mode_e m);
    logic [N_DIV_GRP-1:0] v;
    v = '0;
    case (m)
      MODE_M0: begin
        v[GRP_CPU] = 1'b1;
        v[GRP_V66] = 1'b1;
      end
      MODE_M1, MODE_M3: begin
        v[GRP_CPU]   = 1'b1;
        v[GRP_SDRAM] = 1'b1;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // high phase covers the first ratio/2 counts of each period
  function automatic logic phase_hi(input int unsigned cnt, input int unsigned ratio);
    return cnt < (ratio / 2);
  endfunction

endpackage

// File: rtl/clkmode_strap_latch.sv
module clkmode_strap_latch
  import clkmode_pkg::*;
#(
  parameter logic [STRAP_W-1:0] STRAP_DEFAULT = 3'b011
) (
  input  logic               clk_xtal,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               tri_i,
  output logic [STRAP_W-1:0] strap_q_o,
  output logic               done_o,
  output logic               ref_en_o
);

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) begin
      strap_q_o <= STRAP_DEFAULT;
      done_o    <= 1'b0;
      ref_en_o  <= 1'b0;
    end else begin
      if (!done_o) begin
        strap_q_o <= strap_i;
        done_o    <= 1'b1;
      end
      // REF pin is released from strap duty one edge after capture
      ref_en_o <= done_o & ~tri_i;
    end
  end

endmodule

// File: rtl/clkmode_decode.sv
module clkmode_decode
  import clkmode_pkg::*;
#(
  parameter int DIV_W         = 7,
  parameter int SYN_DIV_CPU66 = 36,
  parameter int SYN_DIV_100   = 24,
  parameter int SYN_DIV_133   = 18,
  parameter int SYN_DIV_V66   = 36,
  parameter int SYN_DIV_PCI   = 72,
  parameter int SYN_DIV_USB   = 50,
  parameter int TST_DIV_FAST  = 2,
  parameter int TST_DIV_V66   = 3,
  parameter int TST_DIV_PCI   = 6
) (
  input  logic [STRAP_W-1:0]                  strap_i,
  output logic                                tri_o,
  output logic                                test_o,
  output logic [N_DIV_GRP-1:0][DIV_W-1:0]     ratio_o,
  output logic [N_DIV_GRP-1:0]                inv_o
);

  localparam logic [DIV_W-1:0] R_CPU66 = DIV_W'(SYN_DIV_CPU66);
  localparam logic [DIV_W-1:0] R_100   = DIV_W'(SYN_DIV_100);
  localparam logic [DIV_W-1:0] R_133   = DIV_W'(SYN_DIV_133);
  localparam logic [DIV_W-1:0] R_V66   = DIV_W'(SYN_DIV_V66);
  localparam logic [DIV_W-1:0] R_PCI   = DIV_W'(SYN_DIV_PCI);
  localparam logic [DIV_W-1:0] R_USB   = DIV_W'(SYN_DIV_USB);
  localparam logic [DIV_W-1:0] T_FAST  = DIV_W'(TST_DIV_FAST);
  localparam logic [DIV_W-1:0] T_V66   = DIV_W'(TST_DIV_V66);
  localparam logic [DIV_W-1:0] T_PCI   = DIV_W'(TST_DIV_PCI);

  clk_mode_e mode;

  always_comb begin
    mode   = decode_strap(strap_i);
    tri_o  = (mode == MODE_TRI);
    test_o = (mode == MODE_TEST);
    inv_o  = inv_mask(mode);

    ratio_o[GRP_V66]  = R_V66;
    ratio_o[GRP_PCI]  = R_PCI;
    ratio_o[GRP_APIC] = R_PCI;
    ratio_o[GRP_USB]  = R_USB;
    case (mode)
      MODE_TEST: begin
        ratio_o[GRP_CPU]   = T_FAST;
        ratio_o[GRP_SDRAM] = T_FAST;
        ratio_o[GRP_V66]   = T_V66;
        ratio_o[GRP_PCI]   = T_PCI;
        ratio_o[GRP_APIC]  = T_PCI;
        ratio_o[GRP_USB]   = T_FAST;
      end
      MODE_M0: begin
        ratio_o[GRP_CPU]   = R_CPU66;
        ratio_o[GRP_SDRAM] = R_100;
      end
      MODE_M2: begin
        ratio_o[GRP_CPU]   = R_133;
        ratio_o[GRP_SDRAM] = R_133;
      end
      MODE_M3: begin
        ratio_o[GRP_CPU]   = R_133;
        ratio_o[GRP_SDRAM] = R_100;
      end
      default: begin
        ratio_o[GRP_CPU]   = R_100;
        ratio_o[GRP_SDRAM] = R_100;
      end
    endcase
  end

endmodule

// File: rtl/clkmode_run_sync.sv
module clkmode_run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic run_o
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      run_o  <= 1'b0;
    end else begin
      meta_q <= req_i;
      run_o  <= meta_q;
    end
  end

endmodule

// File: rtl/clkmode_grp_div.sv
module clkmode_grp_div
  import clkmode_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             invert_i,
  output logic             clk_o,
  output logic             live_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nx;
  logic             hi_now;

  always_comb begin
    cnt_nx = (cnt_q == ratio_i - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);
    hi_now = phase_hi(32'(cnt_q), 32'(ratio_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      clk_o  <= 1'b0;
      live_o <= 1'b0;
    end else if (run_i) begin
      cnt_q  <= cnt_nx;
      clk_o  <= hi_now ^ invert_i;
      live_o <= 1'b1;
    end else begin
      cnt_q  <= '0;
      clk_o  <= 1'b0;
      live_o <= 1'b0;
    end
  end

endmodule

// File: rtl/clkmode_sel_top.sv
module clkmode_sel_top
  import clkmode_pkg::*;
#(
  parameter int N_CPU   = 3,
  parameter int N_SDRAM = 9,
  parameter int N_V66   = 2,
  parameter int N_PCI   = 8,
  parameter int N_APIC  = 2,
  parameter int N_USB   = 2,
  parameter logic [2:0] STRAP_DEFAULT = 3'b011,
  parameter int SYN_DIV_CPU66 = 36,
  parameter int SYN_DIV_100   = 24,
  parameter int SYN_DIV_133   = 18,
  parameter int SYN_DIV_V66   = 36,
  parameter int SYN_DIV_PCI   = 72,
  parameter int SYN_DIV_USB   = 50,
  parameter int TST_DIV_FAST  = 2,
  parameter int TST_DIV_V66   = 3,
  parameter int TST_DIV_PCI   = 6
) (
  input  logic               clk_syn,
  input  logic               clk_xtal,
  input  logic               rst_n,
  input  logic [2:0]         strap_i,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic [N_V66-1:0]   v66_clk_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic [N_APIC-1:0]  apic_clk_o,
  output logic [N_USB-1:0]   usb_clk_o,
  output logic               ref_clk_o,
  output logic [6:0]         grp_oe_o
);

  localparam int MAX_SYN = max_of(max_of(max_of(SYN_DIV_CPU66, SYN_DIV_100),
                                         max_of(SYN_DIV_133, SYN_DIV_V66)),
                                  max_of(SYN_DIV_PCI, SYN_DIV_USB));
  localparam int MAX_TST = max_of(max_of(TST_DIV_FAST, TST_DIV_V66), TST_DIV_PCI);
  localparam int MAX_DIV = max_of(MAX_SYN, MAX_TST);
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [STRAP_W-1:0]            strap_q;
  logic                          strap_done;
  logic                          ref_en;
  logic                          tri_st;
  logic                          test_md;
  logic [N_DIV_GRP-1:0][DIV_W-1:0] grp_ratio;
  logic [N_DIV_GRP-1:0]          grp_inv;
  logic                          div_clk;
  logic                          run_req;
  logic                          run;
  logic [N_DIV_GRP-1:0]          grp_q;
  logic [N_DIV_GRP-1:0]          grp_live;

  clkmode_strap_latch #(.STRAP_DEFAULT(STRAP_DEFAULT)) u_strap (
    .clk_xtal  (clk_xtal),
    .rst_n     (rst_n),
    .strap_i   (strap_i),
    .tri_i     (tri_st),
    .strap_q_o (strap_q),
    .done_o    (strap_done),
    .ref_en_o  (ref_en)
  );

  clkmode_decode #(
    .DIV_W        (DIV_W),
    .SYN_DIV_CPU66(SYN_DIV_CPU66),
    .SYN_DIV_100  (SYN_DIV_100),
    .SYN_DIV_133  (SYN_DIV_133),
    .SYN_DIV_V66  (SYN_DIV_V66),
    .SYN_DIV_PCI  (SYN_DIV_PCI),
    .SYN_DIV_USB  (SYN_DIV_USB),
    .TST_DIV_FAST (TST_DIV_FAST),
    .TST_DIV_V66  (TST_DIV_V66),
    .TST_DIV_PCI  (TST_DIV_PCI)
  ) u_dec (
    .strap_i (strap_q),
    .tri_o   (tri_st),
    .test_o  (test_md),
    .ratio_o (grp_ratio),
    .inv_o   (grp_inv)
  );

  // source select only changes once, while every divider is held idle
  assign div_clk = test_md ? clk_xtal : clk_syn;
  assign run_req = strap_done & ~tri_st;

  clkmode_run_sync u_sync (
    .clk   (div_clk),
    .rst_n (rst_n),
    .req_i (run_req),
    .run_o (run)
  );

  for (genvar g = 0; g < N_DIV_GRP; g++) begin : g_div
    clkmode_grp_div #(.DIV_W(DIV_W)) u_div (
      .clk      (div_clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .ratio_i  (grp_ratio[g]),
      .invert_i (grp_inv[g]),
      .clk_o    (grp_q[g]),
      .live_o   (grp_live[g])
    );
  end

  assign cpu_clk_o   = {N_CPU{grp_q[GRP_CPU]}};
  assign sdram_clk_o = {N_SDRAM{grp_q[GRP_SDRAM]}};
  assign v66_clk_o   = {N_V66{grp_q[GRP_V66]}};
  assign pci_clk_o   = {N_PCI{grp_q[GRP_PCI]}};
  assign apic_clk_o  = {N_APIC{grp_q[GRP_APIC]}};
  assign usb_clk_o   = {N_USB{grp_q[GRP_USB]}};
  assign ref_clk_o   = clk_xtal & ref_en;
  assign grp_oe_o    = {ref_en, grp_live};

endmodule

// File: rtl/clkmode_sel_chk.sv
module clkmode_sel_chk (
  input logic       clk_xtal,
  input logic       div_clk,
  input logic       rst_n,
  input logic [2:0] strap_q,
  input logic       strap_done,
  input logic       tri_st,
  input logic       inv_cpu,
  input logic [5:0] grp_q,
  input logic [6:0] grp_oe_o,
  input logic       cpu0,
  input logic       pci0,
  input logic       apic0
);

  // R1: captured straps never move after capture
  p_strap_frozen_r1: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(strap_q));

  // R6: tri-state keeps every enable low
  p_tri_silent_r6: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (strap_done && tri_st) |-> (grp_oe_o == 7'd0));

  // R10: REF enable held off until straps are captured
  p_ref_hold_r10: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !strap_done |-> !grp_oe_o[6]);

  // R8: divided group enables move together
  p_oe_aligned_r8: assert property (@(posedge div_clk) disable iff (!rst_n)
    (grp_oe_o[5:0] == 6'd0) || (grp_oe_o[5:0] == 6'h3f));

  // R7: first live cycle of the CPU group is its high (or complemented) phase
  p_first_phase_r7: assert property (@(posedge div_clk) disable iff (!rst_n)
    $rose(grp_oe_o[0]) |-> (cpu0 == !inv_cpu));

  // R9: APIC and PCI come from separate dividers yet must match
  p_apic_match_r9: assert property (@(posedge div_clk) disable iff (!rst_n)
    apic0 == pci0);

  // R11: idle groups drive low
  p_idle_low_r11: assert property (@(posedge div_clk) disable iff (!rst_n)
    (grp_oe_o[5:0] == 6'd0) |-> (grp_q == 6'd0));

endmodule

bind clkmode_sel_top clkmode_sel_chk u_chk (
  .clk_xtal   (clk_xtal),
  .div_clk    (div_clk),
  .rst_n      (rst_n),
  .strap_q    (strap_q),
  .strap_done (strap_done),
  .tri_st     (tri_st),
  .inv_cpu    (grp_inv[0]),
  .grp_q      (grp_q),
  .grp_oe_o   (grp_oe_o),
  .cpu0       (cpu_clk_o[0]),
  .pci0       (pci_clk_o[0]),
  .apic0      (apic_clk_o[0])
);

// File: tb/clkmode_sel_top_test.sv
`timescale 1ns/100ps
module clkmode_sel_top_test;

  localparam int CLK_PERIOD  = 4;
  localparam int XTAL_PERIOD = 20;

  logic       clk_syn  = 1'b0;
  logic       clk_xtal = 1'b0;
  logic       rst_n    = 1'b0;
  logic [2:0] strap    = 3'b011;

  logic [2:0] cpu_clk_o;
  logic [8:0] sdram_clk_o;
  logic [1:0] v66_clk_o;
  logic [7:0] pci_clk_o;
  logic [1:0] apic_clk_o;
  logic [1:0] usb_clk_o;
  logic       ref_clk_o;
  logic [6:0] grp_oe_o;

  clkmode_sel_top uut (
    .clk_syn     (clk_syn),
    .clk_xtal    (clk_xtal),
    .rst_n       (rst_n),
    .strap_i     (strap),
    .cpu_clk_o   (cpu_clk_o),
    .sdram_clk_o (sdram_clk_o),
    .v66_clk_o   (v66_clk_o),
    .pci_clk_o   (pci_clk_o),
    .apic_clk_o  (apic_clk_o),
    .usb_clk_o   (usb_clk_o),
    .ref_clk_o   (ref_clk_o),
    .grp_oe_o    (grp_oe_o)
  );

  always #(CLK_PERIOD/2)  clk_syn  = ~clk_syn;
  always #(XTAL_PERIOD/2) clk_xtal = ~clk_xtal;

  typedef struct { logic [5:0] v; string req; } item_t;
  item_t sbq[$];

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  use_test = 1'b0;
  bit  all_done = 1'b0;
  int  exp_r[6];
  bit  exp_inv[6];
  bit  exp_tri;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] grab();
    return {&usb_clk_o, &apic_clk_o, &pci_clk_o, &v66_clk_o, &sdram_clk_o, &cpu_clk_o};
  endfunction

  function automatic bit fan_ok();
    return (cpu_clk_o == '0 || cpu_clk_o == '1) && (sdram_clk_o == '0 || sdram_clk_o == '1) &&
           (v66_clk_o == '0 || v66_clk_o == '1) && (pci_clk_o == '0 || pci_clk_o == '1) &&
           (apic_clk_o == '0 || apic_clk_o == '1) && (usb_clk_o == '0 || usb_clk_o == '1);
  endfunction

  // expectations restated from the requirement text; order CPU,SDRAM,66,PCI,APIC,48
  task automatic set_expect(input logic [2:0] s);
    exp_tri  = (s[1:0] == 2'b00);
    use_test = (s[1:0] == 2'b01);
    foreach (exp_inv[i]) exp_inv[i] = 1'b0;
    if (use_test) begin
      exp_r[0] = 2; exp_r[1] = 2; exp_r[2] = 3; exp_r[3] = 6; exp_r[4] = 6; exp_r[5] = 2;
    end else begin
      exp_r[2] = 36; exp_r[3] = 72; exp_r[4] = 72; exp_r[5] = 50;
      unique case (s)
        3'b010: begin exp_r[0] = 36; exp_r[1] = 24; exp_inv[0] = 1; exp_inv[2] = 1; end
        3'b011: begin exp_r[0] = 24; exp_r[1] = 24; exp_inv[0] = 1; exp_inv[1] = 1; end
        3'b110: begin exp_r[0] = 18; exp_r[1] = 18; end
        default: begin exp_r[0] = 18; exp_r[1] = 24; exp_inv[0] = 1; exp_inv[1] = 1; end
      endcase
    end
  endtask

  // monitor: one compare a quarter period after each source edge
  initial begin
    item_t it;
    logic [5:0] obs;
    forever begin
      if (use_test) @(posedge clk_xtal); else @(posedge clk_syn);
      #1;
      if (sbq.size() > 0) begin
        it  = sbq.pop_front();
        obs = grab();
        check((obs == it.v) && fan_ok(), it.req, {26'd0, obs}, {26'd0, it.v});
      end
    end
  end

  task automatic run_case(input logic [2:0] s, input int nsamp, input bit swap, input logic [2:0] alt, input string tag);
    int tries;
    rst_n = 1'b0;
    strap = s;
    set_expect(s);
    repeat (3) @(posedge clk_xtal);
    #1;
    check(grp_oe_o == 7'd0, "R11", {25'd0, grp_oe_o}, 0);
    check({grab(), ref_clk_o} == 7'd0, "R11", {25'd0, grab(), ref_clk_o}, 0);
    @(negedge clk_xtal);
    rst_n = 1'b1;
    @(posedge clk_xtal);
    #1;
    check(!grp_oe_o[6] && !ref_clk_o, "R10", {31'd0, grp_oe_o[6]}, 0);
    if (swap) strap = alt;
    if (exp_tri) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_xtal);
        #1;
        check(grp_oe_o == 7'd0 && grab() == 6'd0 && !ref_clk_o, "R6",
              {18'd0, grp_oe_o, grab(), ref_clk_o}, 0);
      end
      return;
    end
    tries = 0;
    while (1) begin
      if (use_test) @(negedge clk_xtal); else @(negedge clk_syn);
      tries++;
      if (grp_oe_o[0] || tries > 200) break;
    end
    check(grp_oe_o[5:0] == 6'h3f, "R8", {26'd0, grp_oe_o[5:0]}, 32'h3f);
    for (int k = 1; k <= nsamp; k++) begin
      item_t it;
      for (int g = 0; g < 6; g++)
        it.v[g] = ((k % exp_r[g]) < (exp_r[g] / 2)) ^ exp_inv[g];
      it.req = tag;
      sbq.push_back(it);
    end
    wait (sbq.size() == 0);
    @(posedge clk_xtal);
    #1;
    check(grp_oe_o[6] && ref_clk_o, "R10", {30'd0, grp_oe_o[6], ref_clk_o}, 3);
    @(negedge clk_xtal);
    #1;
    check(!ref_clk_o, "R10", {31'd0, ref_clk_o}, 0);
  endtask

  initial begin
    run_case(3'b011, 160, 1'b0, 3'b000, "R2/R3/R4/R7/R9 strap011");
    run_case(3'b010, 160, 1'b0, 3'b000, "R2/R3/R4/R7 strap010");
    run_case(3'b110, 160, 1'b0, 3'b000, "R2/R3/R4/R7 strap110");
    run_case(3'b111, 160, 1'b1, 3'b001, "R1 strap111 held after pin change");
    run_case(3'b001,  24, 1'b0, 3'b000, "R5/R7 test001");
    run_case(3'b101,  24, 1'b1, 3'b010, "R5/R1 test101");
    run_case(3'b000,   0, 1'b0, 3'b000, "R6");
    run_case(3'b100,   0, 1'b1, 3'b011, "R6");
    all_done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!all_done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, run hung");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule